// File: doc/BRIEF.md
# System Error Interrupt Router

This block sits between a platform's error signals and its interrupt controller. It watches five error sources: the active-low parity-error and system-error pins on both sides of a PCI-style bridge, and an active-high processor-bus error line. For each new error it decides whether to raise a management interrupt (SMI), a non-maskable interrupt (NMI), or nothing. The decision depends on four plain configuration inputs.

When the management path is switched on, it takes every error class, including those that would otherwise go to NMI. When it is off, the NMI path is used, gated by a mask bit. The block also re-drives the secondary-side error pins onto the primary side, each under its own reporting enable.

Every routed error leaves a 4-bit event code for a logging agent. The code is held in a single-entry slot that is read through a valid/ready interface. The code stays stable while `evt_valid` is high and `evt_ready` is low. The slot empties on the cycle where both are high; a new event may be loaded in that same cycle. While the slot holds an unread code, a further routed event is not stored, and a sticky overflow flag is set instead.

Top module: `err_irq_router`

## Requirements
- R1: While `smi_en` is 0, `smi_pulse` never rises for any error.
- R2: While `smi_en` is 1, each reportable error raises `smi_pulse` for one cycle and no `nmi_pulse`, whatever `nmi_mask` holds. The pulse appears on the third rising clock edge after the pin changes.
- R3: While `smi_en` is 0, a reportable error raises a one-cycle `nmi_pulse` only when `nmi_mask` is 0. When `nmi_mask` is 1, no interrupt is raised and no event is logged.
- R4: Parity-error sources are reportable only while `perr_rpt_en` is 1. Bridge system-error sources are reportable only while `serr_rpt_en` is 1. A processor-bus error is always reportable.
- R5: `pri_serr_drv_n` goes low on the third clock edge after `sec_serr_n` goes low, provided `serr_rpt_en` is 1; otherwise it stays high. `pri_perr_drv_n` follows `sec_perr_n` in the same way under `perr_rpt_en`.
- R6: A pin held asserted raises exactly one pulse. A new pulse needs the pin to be released and asserted again.
- R7: Event codes are formed as origin in bits [3:2] (0 primary, 1 secondary, 2 processor) and type in bits [1:0] (1 parity, 2 system). This gives: primary parity 0x1, primary system 0x2, secondary parity 0x5, secondary system 0x6, processor 0xA.
- R8: A routed event loads its code into the slot and raises `evt_valid` in the same cycle as its pulse. The code is held stable until it is accepted with `evt_ready`, after which `evt_valid` falls.
- R9: `evt_ovf` is set, and stays set until reset, whenever a routed event is dropped. An event is dropped if it arrives while the slot is full and not being read, or if it loses a same-cycle tie.
- R10: When several sources are asserted in the same cycle, one pulse is raised and one code is logged. The priority order is processor, primary system, secondary system, primary parity, secondary parity.
- R11: After reset, both pulses are low, both forwarded drivers are high, and `evt_valid` and `evt_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_perr_n | input | 1 | Primary-side parity error, active low |
| pri_serr_n | input | 1 | Primary-side system error, active low |
| sec_perr_n | input | 1 | Secondary-side parity error, active low |
| sec_serr_n | input | 1 | Secondary-side system error, active low |
| cpu_err | input | 1 | Processor-bus error, active high |
| smi_en | input | 1 | Route all errors to the management interrupt |
| serr_rpt_en | input | 1 | System-error reporting and forwarding enable |
| perr_rpt_en | input | 1 | Parity-error reporting and forwarding enable |
| nmi_mask | input | 1 | 1 blocks NMI delivery |
| evt_ready | input | 1 | Logging agent accepts the event code |
| smi_pulse | output | 1 | One-cycle management interrupt request |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| pri_perr_drv_n | output | 1 | Forwarded parity error to the primary side, active low |
| pri_serr_drv_n | output | 1 | Forwarded system error to the primary side, active low |
| evt_valid | output | 1 | Event slot holds a code |
| evt_code | output | 4 | Origin and type of the logged event |
| evt_ovf | output | 1 | Sticky flag: an event was dropped |

## Verification
The routing table is exercised across the four configuration bits and all five sources. Pairs of cases differ in one bit, so each test shows which control alone blocks or redirects an error: the management enable overriding the mask, the mask blocking only the NMI path, and each reporting enable gating only its own error class. Separate patterns cover the following:
- a pin held low over many cycles, which distinguishes edge detection from level detection;
- simultaneous errors, which show the priority order;
- back-to-back errors against a stalled reader, which separate a stall that holds the code from one that overwrites it.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;

  localparam int NSRC = 5;
  localparam int CODE_W = 4;

  // Source indices; lower index wins a same-cycle tie.
  localparam int SRC_CPU      = 0;
  localparam int SRC_PRI_SERR = 1;
  localparam int SRC_SEC_SERR = 2;
  localparam int SRC_PRI_PERR = 3;
  localparam int SRC_SEC_PERR = 4;

  typedef enum logic [1:0] {
    ORG_PRI = 2'd0,
    ORG_SEC = 2'd1,
    ORG_CPU = 2'd2
  } origin_e;

  typedef enum logic [1:0] {
    TYP_PAR = 2'd1,
    TYP_SYS = 2'd2
  } etype_e;

  typedef enum logic [1:0] {
    CLS_ALWAYS = 2'd0,
    CLS_SYS    = 2'd1,
    CLS_PAR    = 2'd2
  } gate_cls_e;

  function automatic gate_cls_e src_class(input int idx);
    case (idx)
      SRC_CPU:                   return CLS_ALWAYS;
      SRC_PRI_SERR, SRC_SEC_SERR: return CLS_SYS;
      default:                   return CLS_PAR;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_CPU:      return {ORG_CPU, TYP_SYS};
      SRC_PRI_SERR: return {ORG_PRI, TYP_SYS};
      SRC_SEC_SERR: return {ORG_SEC, TYP_SYS};
      SRC_PRI_PERR: return {ORG_PRI, TYP_PAR};
      default:      return {ORG_SEC, TYP_PAR};
    endcase
  endfunction

endpackage

// File: rtl/err_pin_sync.sv
module err_pin_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], raw_i[b]};
    end
    assign lvl_o[b] = chain[LAST];
  end

endmodule

// File: rtl/err_route.sv
module err_route
  import err_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      lvl_i,
  input  logic              smi_en,
  input  logic              nmi_mask,
  input  logic              serr_en,
  input  logic              perr_en,
  output logic              smi_fire,
  output logic              nmi_fire,
  output logic [CODE_W-1:0] code,
  output logic              extra
);

  logic [N-1:0] prev;
  logic [N-1:0] rise;
  logic [N-1:0] gate;
  logic [N-1:0] rep;
  logic         any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl_i;
  end

  assign rise = lvl_i & ~prev;

  for (genvar i = 0; i < N; i++) begin : g_gate
    if (src_class(i) == CLS_ALWAYS) begin : g_always
      assign gate[i] = 1'b1;
    end else if (src_class(i) == CLS_SYS) begin : g_sys
      assign gate[i] = serr_en;
    end else begin : g_par
      assign gate[i] = perr_en;
    end
  end

  assign rep = rise & gate;
  assign any = |rep;

  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rep[i]) code = src_code(i);
    end
  end

  assign smi_fire = any & smi_en;
  assign nmi_fire = any & ~smi_en & ~nmi_mask;
  assign extra    = (smi_fire | nmi_fire) && ($countones(rep) > 1);

endmodule

// File: rtl/err_evt_slot.sv
module err_evt_slot #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_code,
  input  logic         drop,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] code,
  output logic         ovf
);

  logic pop;
  logic room;

  assign pop  = valid & ready;
  assign room = ~valid | ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push && room) begin
        valid <= 1'b1;
        code  <= push_code;
      end else if (pop) begin
        valid <= 1'b0;
      end
      if ((push && !room) || drop) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/err_irq_router.sv
module err_irq_router
  import err_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_perr_n,
  input  logic              pri_serr_n,
  input  logic              sec_perr_n,
  input  logic              sec_serr_n,
  input  logic              cpu_err,
  input  logic              smi_en,
  input  logic              serr_rpt_en,
  input  logic              perr_rpt_en,
  input  logic              nmi_mask,
  input  logic              evt_ready,
  output logic              smi_pulse,
  output logic              nmi_pulse,
  output logic              pri_perr_drv_n,
  output logic              pri_serr_drv_n,
  output logic              evt_valid,
  output logic [CODE_W-1:0] evt_code,
  output logic              evt_ovf
);

  logic [NSRC-1:0]   raw;
  logic [NSRC-1:0]   lvl;
  logic              smi_fire;
  logic              nmi_fire;
  logic              extra;
  logic [CODE_W-1:0] fire_code;

  // Active-high view of every source, indexed by priority.
  always_comb begin
    raw               = '0;
    raw[SRC_CPU]      = cpu_err;
    raw[SRC_PRI_SERR] = ~pri_serr_n;
    raw[SRC_SEC_SERR] = ~sec_serr_n;
    raw[SRC_PRI_PERR] = ~pri_perr_n;
    raw[SRC_SEC_PERR] = ~sec_perr_n;
  end

  err_pin_sync #(.N(NSRC), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (raw),
    .lvl_o (lvl)
  );

  err_route #(.N(NSRC)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_i    (lvl),
    .smi_en   (smi_en),
    .nmi_mask (nmi_mask),
    .serr_en  (serr_rpt_en),
    .perr_en  (perr_rpt_en),
    .smi_fire (smi_fire),
    .nmi_fire (nmi_fire),
    .code     (fire_code),
    .extra    (extra)
  );

  err_evt_slot #(.W(CODE_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (smi_fire | nmi_fire),
    .push_code (fire_code),
    .drop      (extra),
    .valid     (evt_valid),
    .ready     (evt_ready),
    .code      (evt_code),
    .ovf       (evt_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_pulse      <= 1'b0;
      nmi_pulse      <= 1'b0;
      pri_serr_drv_n <= 1'b1;
      pri_perr_drv_n <= 1'b1;
    end else begin
      smi_pulse      <= smi_fire;
      nmi_pulse      <= nmi_fire;
      pri_serr_drv_n <= ~(lvl[SRC_SEC_SERR] & serr_rpt_en);
      pri_perr_drv_n <= ~(lvl[SRC_SEC_PERR] & perr_rpt_en);
    end
  end

endmodule

// File: rtl/err_irq_router_chk.sv
module err_irq_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smi_en,
  input logic       serr_rpt_en,
  input logic       perr_rpt_en,
  input logic       nmi_mask,
  input logic       evt_ready,
  input logic       smi_pulse,
  input logic       nmi_pulse,
  input logic       pri_perr_drv_n,
  input logic       pri_serr_drv_n,
  input logic       evt_valid,
  input logic [3:0] evt_code,
  input logic       evt_ovf
);

  // R1: a management pulse only follows a cycle with the enable set
  assert_smi_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(smi_en));

  // R2: management path pre-empts NMI
  assert_smi_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(smi_pulse && nmi_pulse));

  // R3: NMI requires unmasked and management path off
  assert_nmi_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> ($past(!nmi_mask) && $past(!smi_en)));

  // R5: forwarding is blocked when its enable was clear
  assert_serr_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(serr_rpt_en) |-> pri_serr_drv_n);
  assert_perr_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(perr_rpt_en) |-> pri_perr_drv_n);

  // R8: a stalled code holds still
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code)));

  // R8: slot fills only with a routed event
  assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_valid) |-> (smi_pulse || nmi_pulse));

  // R9: overflow is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovf |=> evt_ovf);

endmodule

bind err_irq_router err_irq_router_chk u_chk (.*);

// File: tb/tb_err_irq_router.sv
module tb_err_irq_router;

  typedef struct packed {
    logic       smi;
    logic       mask;
    logic       se;
    logic       pe;
    logic [2:0] src;
    logic       esmi;
    logic       enmi;
    logic       elog;
    logic [3:0] code;
  } vec_t;

  // src: 0 cpu, 1 pri serr, 2 sec serr, 3 pri perr, 4 sec perr
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 4'hA},
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b1, 4'h2},
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 1'b1, 4'h2},
    '{1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'h0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 1'b1, 1'b1, 4'h5},
    '{1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 4'h0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'h0},
    '{1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 4'hA},
    '{1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 1'b1, 4'h1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 4'h6},
    '{1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pri_perr_n = 1'b1, pri_serr_n = 1'b1, sec_perr_n = 1'b1, sec_serr_n = 1'b1;
  logic cpu_err = 1'b0;
  logic smi_en = 1'b0, serr_rpt_en = 1'b0, perr_rpt_en = 1'b0, nmi_mask = 1'b0;
  logic evt_ready = 1'b0;
  logic smi_pulse, nmi_pulse, pri_perr_drv_n, pri_serr_drv_n, evt_valid, evt_ovf;
  logic [3:0] evt_code;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  err_irq_router dut (
    .clk(clk), .rst_n(rst_n),
    .pri_perr_n(pri_perr_n), .pri_serr_n(pri_serr_n),
    .sec_perr_n(sec_perr_n), .sec_serr_n(sec_serr_n),
    .cpu_err(cpu_err), .smi_en(smi_en), .serr_rpt_en(serr_rpt_en),
    .perr_rpt_en(perr_rpt_en), .nmi_mask(nmi_mask), .evt_ready(evt_ready),
    .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse),
    .pri_perr_drv_n(pri_perr_drv_n), .pri_serr_drv_n(pri_serr_drv_n),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_ovf(evt_ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_src(input int s, input logic on);
    case (s)
      0: cpu_err    = on;
      1: pri_serr_n = ~on;
      2: sec_serr_n = ~on;
      3: pri_perr_n = ~on;
      default: sec_perr_n = ~on;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_err = 1'b0; pri_serr_n = 1'b1; sec_serr_n = 1'b1;
    pri_perr_n = 1'b1; sec_perr_n = 1'b1; evt_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pop();
    evt_ready = 1'b1;
    @(negedge clk);
    evt_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", "smi_pulse", smi_pulse, 0);
    chk("R11", "nmi_pulse", nmi_pulse, 0);
    chk("R11", "pri_serr_drv_n", pri_serr_drv_n, 1);
    chk("R11", "pri_perr_drv_n", pri_perr_drv_n, 1);
    chk("R11", "evt_valid", evt_valid, 0);
    chk("R11", "evt_ovf", evt_ovf, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector walk: R1 R2 R3 R4 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      smi_en = VECS[v].smi; nmi_mask = VECS[v].mask;
      serr_rpt_en = VECS[v].se; perr_rpt_en = VECS[v].pe;
      repeat (2) @(negedge clk);
      set_src(int'(VECS[v].src), 1'b1);
      repeat (3) @(negedge clk);
      chk("R1/R2", $sformatf("vec%0d smi", v), smi_pulse, VECS[v].esmi);
      chk("R3/R4", $sformatf("vec%0d nmi", v), nmi_pulse, VECS[v].enmi);
      chk("R8", $sformatf("vec%0d valid", v), evt_valid, VECS[v].elog);
      if (VECS[v].elog)
        chk("R7", $sformatf("vec%0d code", v), evt_code, VECS[v].code);
      @(negedge clk);
      chk("R6", $sformatf("vec%0d pulse width", v), smi_pulse | nmi_pulse, 0);
      set_src(int'(VECS[v].src), 1'b0);
      pop();
      chk("R8", $sformatf("vec%0d popped", v), evt_valid, 0);
      chk("R9", $sformatf("vec%0d no ovf", v), evt_ovf, 0);
      repeat (3) @(negedge clk);
    end

    // R6: a held pin gives one pulse
    smi_en = 1'b1; serr_rpt_en = 1'b1; perr_rpt_en = 1'b1; nmi_mask = 1'b0;
    evt_ready = 1'b1;
    pri_serr_n = 1'b0;
    pulses = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (smi_pulse) pulses++;
    end
    chk("R6", "pulses while held", pulses, 1);
    pri_serr_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: forwarding latency and enables
    sec_serr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5", "serr drv before latency", pri_serr_drv_n, 1);
    @(negedge clk);
    chk("R5", "serr drv forwarded", pri_serr_drv_n, 0);
    serr_rpt_en = 1'b0;
    @(negedge clk);
    chk("R5", "serr drv disabled", pri_serr_drv_n, 1);
    sec_serr_n = 1'b1;
    perr_rpt_en = 1'b0;
    sec_perr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5", "perr drv disabled", pri_perr_drv_n, 1);
    perr_rpt_en = 1'b1;
    @(negedge clk);
    chk("R5", "perr drv forwarded", pri_perr_drv_n, 0);
    sec_perr_n = 1'b1;
    serr_rpt_en = 1'b1;
    repeat (4) @(negedge clk);
    evt_ready = 1'b0;

    // R8 / R9: stalled reader, second event dropped
    do_reset();
    pri_serr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "first code", evt_code, 4'h2);
    pri_serr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "held valid", evt_valid, 1);
    sec_perr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "ovf on full slot", evt_ovf, 1);
    chk("R8", "code kept", evt_code, 4'h2);
    sec_perr_n = 1'b1;
    pop();
    chk("R8", "valid after pop", evt_valid, 0);
    chk("R9", "ovf sticky", evt_ovf, 1);

    // R10: same-cycle priority
    do_reset();
    pri_perr_n = 1'b0; sec_serr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "tie pulse", smi_pulse, 1);
    chk("R10", "tie code", evt_code, 4'h6);
    chk("R9", "tie drop ovf", evt_ovf, 1);
    pri_perr_n = 1'b1; sec_serr_n = 1'b1;
    @(negedge clk);
    pop();
    cpu_err = 1'b1; pri_serr_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "cpu wins code", evt_code, 4'hA);
    cpu_err = 1'b0; pri_serr_n = 1'b1;
    pop();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule